// File: doc/BRIEF.md
# PTP System Time Unit

This block maintains a free-running system clock for precision time protocol work, split into a seconds count and a subseconds count that wraps at 2^31. Each enabled clock the subseconds advance by a programmed increment. In coarse mode the increment is added on every enabled cycle. In fine mode a 32-bit addend is summed into an accumulator, and the increment is added only on the cycles where that accumulator carries out. Fine mode lets software trim the effective rate of the clock to a fraction of one increment.

Software controls the time through command pulses. An initialize command overwrites the time with the update words. An update command adds the update words to the current time, or subtracts them from it. Each command shows a busy flag for exactly one cycle, after which the flag clears itself. Software polls the flag. A request that arrives while a command is still pending is dropped.

A one-shot target comparison can be armed. When the time passes the target, it raises a sticky interrupt flag and disarms itself. A valid flag shows that the time has been initialized since the block was last enabled.

Top module: `ptp_systime_unit`

## Requirements
- R1: An initialize request accepted while idle raises `init_busy_o` for one cycle. On the next edge the time is overwritten with `upd_sec_i` and the low 31 bits of `upd_sub_i`, both captured when the request was accepted, and `init_busy_o` clears itself.
- R2: An initialize request seen while `init_busy_o` is high is ignored, and the time ends up with the values from the first request.
- R3: An update request with bit 31 of `upd_sub_i` clear adds the captured words to the time one cycle after acceptance, and `upd_busy_o` is high for that one cycle. When the subseconds sum reaches 2^31 or more, 2^31 is removed from it and one extra second is carried.
- R4: An update request with bit 31 of `upd_sub_i` set subtracts the captured seconds and the 31-bit subseconds magnitude from the time. When the subseconds would go negative, 2^31 is added to them and one extra second is borrowed.
- R5: An update request is accepted only while both busy flags are low. An update request during a pending initialize is dropped. When initialize and update are requested in the same cycle, initialize wins and the update is dropped.
- R6: With `en_i` high and `fine_i` low, the subseconds grow by `incr_i` on every cycle without a pending command. Reaching 2^31 wraps them and adds one second.
- R7: With `en_i` high and `fine_i` high, `addend_i` is summed into a 32-bit accumulator every cycle. `incr_i` is added to the time only on the cycles where that sum carries out of 32 bits.
- R8: While `en_i` is low and no command is pending, the time holds its value.
- R9: `valid_o` rises when an initialize is applied while `en_i` is high, and falls on the first edge with `en_i` low. A time that was merely enabled, without an initialize, is never valid.
- R10: A pulse on `trig_arm_i` sets `armed_o`. While armed, a time strictly greater than the target, comparing seconds first and then subseconds, sets `irq_o` and clears `armed_o` on the same edge. A time equal to the target does not fire.
- R11: `irq_o` stays set until a cycle with `irq_clr_i` high. Once disarmed, the comparator does not fire again.
- R12: After reset the time is zero, and all flags (`init_busy_o`, `upd_busy_o`, `valid_o`, `irq_o`, `armed_o`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Time counting enable |
| fine_i | input | 1 | 1 = fine (accumulator) update, 0 = coarse |
| init_req_i | input | 1 | Initialize command pulse |
| upd_req_i | input | 1 | Add/subtract command pulse |
| upd_sec_i | input | 32 | Update seconds word |
| upd_sub_i | input | 32 | Update subseconds word; bit 31 selects subtract |
| incr_i | input | 8 | Subseconds increment per tick |
| addend_i | input | 32 | Fine-mode accumulator addend |
| tgt_sec_i | input | 32 | Target seconds |
| tgt_sub_i | input | 31 | Target subseconds |
| trig_arm_i | input | 1 | Arms the target comparison |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| sec_o | output | 32 | System time seconds |
| sub_o | output | 31 | System time subseconds |
| init_busy_o | output | 1 | Initialize pending |
| upd_busy_o | output | 1 | Update pending |
| valid_o | output | 1 | Time initialized since enable |
| irq_o | output | 1 | Target-time interrupt flag |
| armed_o | output | 1 | Target comparison armed |

## Verification
The bench drives add and subtract updates that carry across the 2^31 subseconds boundary and borrow across it. A design that wrapped at 2^32, or that lost the extra second, would leave the seconds off by one. It sends requests into the busy window and sends initialize and update together. A design without the interlock would apply the later values, or would apply an add on top of the initialize. It sets the time exactly equal to the target and then one past it. An off-by-one comparator would fire early, and a comparator that does not disarm would fire again after the flag is cleared. Fine mode runs with a half-range addend, so a design that added the increment every cycle would show twice the expected subseconds.

// File: rtl/ptp_time_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the PTP system time unit.
// Assumes: one command at most may be in flight at any time.
package ptp_time_pkg;

    // Command handshake state; each busy state lasts exactly one cycle.
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_INIT = 2'd1,
        CMD_UPD  = 2'd2
    } cmd_state_e;

endpackage

// File: rtl/ptp_cmd_ctrl.sv
`timescale 1ns/1ps
// Module: ptp_cmd_ctrl
// Accepts initialize and add/subtract requests, captures the update words
// and holds the command pending for one cycle, during which further
// requests are dropped. Initialize wins over a simultaneous update.
// Assumes: requests are single-cycle pulses from a register write.
module ptp_cmd_ctrl
    import ptp_time_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             upd_req,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W:0]   upd_sub,
    output logic             apply_init,
    output logic             apply_upd,
    output logic [SEC_W-1:0] cap_sec,
    output logic [SUB_W:0]   cap_sub
);

    cmd_state_e state_q;

    // Next-state logic: accept only from idle, then return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
        end else if (state_q == CMD_IDLE) begin
            if (init_req)
                state_q <= CMD_INIT;
            else if (upd_req)
                state_q <= CMD_UPD;
        end else begin
            state_q <= CMD_IDLE;
        end
    end

    // Capture the update words at acceptance so later writes cannot disturb them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sec <= '0;
            cap_sub <= '0;
        end else if (state_q == CMD_IDLE && (init_req || upd_req)) begin
            cap_sec <= upd_sec;
            cap_sub <= upd_sub;
        end
    end

    // Pending flags double as the apply strobes for the time core.
    always_comb begin
        apply_init = (state_q == CMD_INIT);
        apply_upd  = (state_q == CMD_UPD);
    end

endmodule

// File: rtl/ptp_tick_gen.sv
`timescale 1ns/1ps
// Module: ptp_tick_gen
// Decides on which cycles the subsecond increment is applied. Coarse mode
// steps on every enabled cycle. Fine mode sums an addend into an
// accumulator and steps on its carry-out.
// Assumes: the accumulator keeps its value while disabled or in coarse mode.
module ptp_tick_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fine,
    input  logic [ACC_W-1:0] addend,
    output logic             step
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    // Accumulator sum with carry bit.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, addend};
        step    = en && (fine ? acc_sum[ACC_W] : 1'b1);
    end

    // Accumulator register, advancing only in enabled fine mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en && fine)
            acc_q <= acc_sum[ACC_W-1:0];
    end

endmodule

// File: rtl/ptp_time_core.sv
`timescale 1ns/1ps
// Module: ptp_time_core
// Holds the seconds/subseconds time. Priority: initialize overwrite,
// then add/subtract update, then the regular tick. Subseconds wrap at
// 2^SUB_W with carry or borrow into the seconds. Also keeps the valid flag.
// Assumes: INC_W <= SUB_W; a tick coinciding with a command apply is dropped.
module ptp_time_core #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             apply_init,
    input  logic             apply_upd,
    input  logic [SEC_W-1:0] cap_sec,
    input  logic [SUB_W:0]   cap_sub,
    input  logic             step,
    input  logic [INC_W-1:0] incr,
    output logic [SEC_W-1:0] sec,
    output logic [SUB_W-1:0] sub,
    output logic             valid
);

    localparam int PAD_W = SUB_W + 1 - INC_W;

    logic [SEC_W-1:0] sec_q, sec_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic             valid_q;
    logic [SUB_W-1:0] mag;
    logic             negate;
    logic [SUB_W:0]   add_sum;
    logic [SUB_W:0]   dif;
    logic [SUB_W:0]   tick_sum;

    // Arithmetic for the update and tick paths.
    always_comb begin
        mag      = cap_sub[SUB_W-1:0];
        negate   = cap_sub[SUB_W];
        add_sum  = {1'b0, sub_q} + {1'b0, mag};
        dif      = {1'b0, sub_q} - {1'b0, mag};
        tick_sum = {1'b0, sub_q} + {{PAD_W{1'b0}}, incr};
    end

    // Next-time selection by priority.
    always_comb begin
        sec_d = sec_q;
        sub_d = sub_q;
        if (apply_init) begin
            sec_d = cap_sec;
            sub_d = mag;
        end else if (apply_upd) begin
            if (negate) begin
                sub_d = dif[SUB_W-1:0];
                sec_d = sec_q - cap_sec - {{(SEC_W-1){1'b0}}, dif[SUB_W]};
            end else begin
                sub_d = add_sum[SUB_W-1:0];
                sec_d = sec_q + cap_sec + {{(SEC_W-1){1'b0}}, add_sum[SUB_W]};
            end
        end else if (step) begin
            sub_d = tick_sum[SUB_W-1:0];
            sec_d = sec_q + {{(SEC_W-1){1'b0}}, tick_sum[SUB_W]};
        end
    end

    // Time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else begin
            sec_q <= sec_d;
            sub_q <= sub_d;
        end
    end

    // Valid flag: set by an initialize while enabled, dropped when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else if (!en)
            valid_q <= 1'b0;
        else if (apply_init)
            valid_q <= 1'b1;
    end

    assign sec   = sec_q;
    assign sub   = sub_q;
    assign valid = valid_q;

endmodule

// File: rtl/ptp_target_cmp.sv
`timescale 1ns/1ps
// Module: ptp_target_cmp
// One-shot comparison of the time against a target. While armed, a time
// strictly greater than the target sets a sticky interrupt flag and
// disarms. The flag clears on a clear pulse, and setting wins over clearing.
// Assumes: target words are held stable by software while armed.
module ptp_target_cmp #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec,
    input  logic [SUB_W-1:0] sub,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    input  logic             arm,
    input  logic             clr,
    output logic             armed,
    output logic             irq
);

    logic armed_q, irq_q, passed, fire;

    // Strict greater-than, seconds first.
    always_comb begin
        passed = (sec > tgt_sec) || ((sec == tgt_sec) && (sub > tgt_sub));
        fire   = armed_q && passed;
    end

    // Arm register: a fire disarms it, an arm pulse sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (fire)
            armed_q <= 1'b0;
        else if (arm)
            armed_q <= 1'b1;
    end

    // Sticky interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (fire)
            irq_q <= 1'b1;
        else if (clr)
            irq_q <= 1'b0;
    end

    assign armed = armed_q;
    assign irq   = irq_q;

endmodule

// File: rtl/ptp_systime_unit.sv
`timescale 1ns/1ps
// Module: ptp_systime_unit (top)
// Seconds/subseconds system time with a command handshake for initialize
// and add/subtract, a coarse or fine tick source and a one-shot target
// interrupt.
// Assumes: software polls the busy flags before issuing a new command.
module ptp_systime_unit #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             fine_i,
    input  logic             init_req_i,
    input  logic             upd_req_i,
    input  logic [SEC_W-1:0] upd_sec_i,
    input  logic [SUB_W:0]   upd_sub_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic [ACC_W-1:0] addend_i,
    input  logic [SEC_W-1:0] tgt_sec_i,
    input  logic [SUB_W-1:0] tgt_sub_i,
    input  logic             trig_arm_i,
    input  logic             irq_clr_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             init_busy_o,
    output logic             upd_busy_o,
    output logic             valid_o,
    output logic             irq_o,
    output logic             armed_o
);

    logic             apply_init, apply_upd, step;
    logic [SEC_W-1:0] cap_sec;
    logic [SUB_W:0]   cap_sub;

    ptp_cmd_ctrl #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_req   (init_req_i),
        .upd_req    (upd_req_i),
        .upd_sec    (upd_sec_i),
        .upd_sub    (upd_sub_i),
        .apply_init (apply_init),
        .apply_upd  (apply_upd),
        .cap_sec    (cap_sec),
        .cap_sub    (cap_sub)
    );

    ptp_tick_gen #(.ACC_W(ACC_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_i),
        .fine   (fine_i),
        .addend (addend_i),
        .step   (step)
    );

    ptp_time_core #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_i),
        .apply_init (apply_init),
        .apply_upd  (apply_upd),
        .cap_sec    (cap_sec),
        .cap_sub    (cap_sub),
        .step       (step),
        .incr       (incr_i),
        .sec        (sec_o),
        .sub        (sub_o),
        .valid      (valid_o)
    );

    ptp_target_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec     (sec_o),
        .sub     (sub_o),
        .tgt_sec (tgt_sec_i),
        .tgt_sub (tgt_sub_i),
        .arm     (trig_arm_i),
        .clr     (irq_clr_i),
        .armed   (armed_o),
        .irq     (irq_o)
    );

    // The busy flags are the pending-command strobes.
    assign init_busy_o = apply_init;
    assign upd_busy_o  = apply_upd;

endmodule

// File: rtl/ptp_systime_unit_chk.sv
`timescale 1ns/1ps
// Module: ptp_systime_unit_chk
// Temporal checks on the top-level ports of ptp_systime_unit, attached by bind.
module ptp_systime_unit_chk #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             irq_clr_i,
    input logic [SEC_W-1:0] sec_o,
    input logic [SUB_W-1:0] sub_o,
    input logic             init_busy_o,
    input logic             upd_busy_o,
    input logic             valid_o,
    input logic             irq_o,
    input logic             armed_o
);

    // R1: initialize busy lasts one cycle
    p_init_selfclear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy_o |=> !init_busy_o);

    // R3: update busy lasts one cycle
    p_upd_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_busy_o |=> !upd_busy_o);

    // R5: never two commands pending at once
    p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_busy_o && upd_busy_o));

    // R8: time holds while disabled and idle
    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !init_busy_o && !upd_busy_o) |=> ($stable(sec_o) && $stable(sub_o)));

    // R9: disabling drops validity
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o);

    // R10: a firing disarms the comparator
    p_fire_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !armed_o);

    // R11: interrupt flag is sticky until cleared
    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);

endmodule

bind ptp_systime_unit ptp_systime_unit_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .irq_clr_i   (irq_clr_i),
    .sec_o       (sec_o),
    .sub_o       (sub_o),
    .init_busy_o (init_busy_o),
    .upd_busy_o  (upd_busy_o),
    .valid_o     (valid_o),
    .irq_o       (irq_o),
    .armed_o     (armed_o)
);

// File: tb/ptp_systime_unit_test.sv
`timescale 1ns/1ps
module ptp_systime_unit_test;

    localparam logic [31:0] HALF = 32'h8000_0000;
    localparam logic [31:0] NEG  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, fine_i = 1'b0;
    logic        init_req_i = 1'b0, upd_req_i = 1'b0;
    logic [31:0] upd_sec_i = '0, upd_sub_i = '0;
    logic [7:0]  incr_i = '0;
    logic [31:0] addend_i = '0;
    logic [31:0] tgt_sec_i = '0;
    logic [30:0] tgt_sub_i = '0;
    logic        trig_arm_i = 1'b0, irq_clr_i = 1'b0;
    logic [31:0] sec_o;
    logic [30:0] sub_o;
    logic        init_busy_o, upd_busy_o, valid_o, irq_o, armed_o;

    always #10 clk = ~clk;

    ptp_systime_unit uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .fine_i(fine_i),
        .init_req_i(init_req_i), .upd_req_i(upd_req_i),
        .upd_sec_i(upd_sec_i), .upd_sub_i(upd_sub_i), .incr_i(incr_i),
        .addend_i(addend_i), .tgt_sec_i(tgt_sec_i), .tgt_sub_i(tgt_sub_i),
        .trig_arm_i(trig_arm_i), .irq_clr_i(irq_clr_i),
        .sec_o(sec_o), .sub_o(sub_o), .init_busy_o(init_busy_o),
        .upd_busy_o(upd_busy_o), .valid_o(valid_o), .irq_o(irq_o),
        .armed_o(armed_o)
    );

    // Scoreboard item: which output, expected value, requirement tag.
    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int S_SEC = 0, S_SUB = 1, S_IB = 2, S_UB = 3, S_VAL = 4, S_IRQ = 5, S_ARM = 6;

    task automatic expect_out(input string req, input int sel, input logic [31:0] v);
        item_t it;
        it.req = req; it.sel = sel; it.exp = v;
        q.push_back(it);
    endtask

    function automatic logic [31:0] pick(input int sel);
        case (sel)
            S_SEC:   return sec_o;
            S_SUB:   return {1'b0, sub_o};
            S_IB:    return {31'd0, init_busy_o};
            S_UB:    return {31'd0, upd_busy_o};
            S_VAL:   return {31'd0, valid_o};
            S_IRQ:   return {31'd0, irq_o};
            default: return {31'd0, armed_o};
        endcase
    endfunction

    // Monitor: pops expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = pick(it.sel);
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s (sel %0d): actual %0h expected %0h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Initialize: busy one cycle, then the time equals the words.
    task automatic do_init(input logic [31:0] s, input logic [31:0] sb, input string req);
        init_req_i = 1'b1; upd_sec_i = s; upd_sub_i = sb;
        @(negedge clk);
        init_req_i = 1'b0;
        expect_out(req, S_IB, 1);
        @(negedge clk);
        expect_out(req, S_IB, 0);
        expect_out(req, S_SEC, s);
        expect_out(req, S_SUB, {1'b0, sb[30:0]});
    endtask

    // Update: busy one cycle, then the time equals the expected sum.
    task automatic do_upd(input logic [31:0] s, input logic [31:0] sb,
                          input logic [31:0] es, input logic [31:0] esb, input string req);
        upd_req_i = 1'b1; upd_sec_i = s; upd_sub_i = sb;
        @(negedge clk);
        upd_req_i = 1'b0;
        expect_out(req, S_UB, 1);
        @(negedge clk);
        expect_out(req, S_UB, 0);
        expect_out(req, S_SEC, es);
        expect_out(req, S_SUB, esb);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R12: reset state
        expect_out("R12", S_SEC, 0); expect_out("R12", S_SUB, 0);
        expect_out("R12", S_IB, 0);  expect_out("R12", S_UB, 0);
        expect_out("R12", S_VAL, 0); expect_out("R12", S_IRQ, 0);
        expect_out("R12", S_ARM, 0);
        tick(1);

        // R1: overwrite while disabled; R9 not valid since disabled
        do_init(32'd5, 32'd100, "R1");
        expect_out("R9", S_VAL, 0);
        tick(1);
        expect_out("R8", S_SEC, 5); expect_out("R8", S_SUB, 100);

        // R3: plain add, then add with carry at 2^31
        do_upd(32'd2, 32'd50, 32'd7, 32'd150, "R3");
        do_upd(32'd0, HALF - 32'd100, 32'd8, 32'd50, "R3");
        // R4: subtract with borrow, then without
        do_upd(32'd1, NEG | 32'd100, 32'd6, HALF - 32'd50, "R4");
        do_upd(32'd1, NEG | 32'd10, 32'd5, HALF - 32'd60, "R4");

        // R2: second initialize during busy is ignored
        init_req_i = 1'b1; upd_sec_i = 32'd40; upd_sub_i = 32'd7;
        @(negedge clk);
        upd_sec_i = 32'd41; upd_sub_i = 32'd9;
        @(negedge clk);
        init_req_i = 1'b0;
        expect_out("R2", S_SEC, 40); expect_out("R2", S_SUB, 7);
        expect_out("R2", S_IB, 0);
        tick(1);
        expect_out("R2", S_SEC, 40); expect_out("R2", S_SUB, 7);

        // R5: update during a pending initialize is dropped
        init_req_i = 1'b1; upd_sec_i = 32'd50; upd_sub_i = 32'd1;
        @(negedge clk);
        init_req_i = 1'b0; upd_req_i = 1'b1; upd_sec_i = 32'd3; upd_sub_i = 32'd3;
        @(negedge clk);
        upd_req_i = 1'b0;
        expect_out("R5", S_UB, 0);
        expect_out("R5", S_SEC, 50); expect_out("R5", S_SUB, 1);
        tick(1);
        expect_out("R5", S_SEC, 50); expect_out("R5", S_SUB, 1);

        // R5: simultaneous requests, initialize wins
        init_req_i = 1'b1; upd_req_i = 1'b1; upd_sec_i = 32'd60; upd_sub_i = 32'd2;
        @(negedge clk);
        init_req_i = 1'b0; upd_req_i = 1'b0;
        expect_out("R5", S_IB, 1); expect_out("R5", S_UB, 0);
        tick(1);
        expect_out("R5", S_SEC, 60); expect_out("R5", S_SUB, 2);
        tick(1);
        expect_out("R5", S_SEC, 60); expect_out("R5", S_SUB, 2);

        // R6: coarse ticking across the subseconds wrap; R9 valid after init
        en_i = 1'b1; fine_i = 1'b0; incr_i = 8'd10;
        do_init(32'd10, HALF - 32'd25, "R6");
        expect_out("R9", S_VAL, 1);
        tick(3);
        expect_out("R6", S_SEC, 11); expect_out("R6", S_SUB, 5);
        // R8 / R9: disable holds time and drops validity
        en_i = 1'b0;
        tick(1);
        expect_out("R8", S_SEC, 11); expect_out("R8", S_SUB, 5);
        expect_out("R9", S_VAL, 0);
        tick(2);
        expect_out("R8", S_SEC, 11); expect_out("R8", S_SUB, 5);

        // R7: fine mode with half-range addend steps every second cycle
        fine_i = 1'b1; incr_i = 8'd4; addend_i = HALF;
        do_init(32'd0, 32'd0, "R7");
        en_i = 1'b1;
        tick(1);
        expect_out("R7", S_SUB, 0);
        tick(3);
        expect_out("R7", S_SUB, 8); expect_out("R7", S_SEC, 0);
        expect_out("R9", S_VAL, 0);
        en_i = 1'b0; fine_i = 1'b0;

        // R10: arm, equal does not fire, greater fires and disarms
        do_init(32'd20, 32'd0, "R10");
        tgt_sec_i = 32'd20; tgt_sub_i = 31'd5;
        trig_arm_i = 1'b1;
        @(negedge clk);
        trig_arm_i = 1'b0;
        expect_out("R10", S_ARM, 1); expect_out("R10", S_IRQ, 0);
        do_upd(32'd0, 32'd5, 32'd20, 32'd5, "R10");
        tick(1);
        expect_out("R10", S_ARM, 1); expect_out("R10", S_IRQ, 0);
        do_upd(32'd0, 32'd1, 32'd20, 32'd6, "R10");
        expect_out("R10", S_IRQ, 0);
        tick(1);
        expect_out("R10", S_IRQ, 1); expect_out("R10", S_ARM, 0);
        // R11: sticky until cleared, no refire once disarmed
        tick(2);
        expect_out("R11", S_IRQ, 1);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        expect_out("R11", S_IRQ, 0);
        tick(2);
        expect_out("R11", S_IRQ, 0); expect_out("R11", S_ARM, 0);

        tick(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule